// File: doc/BRIEF.md
# Hash Accelerator Interrupt and Context-Switch Controller

This block produces the interrupt signalling for a hash accelerator. It keeps four sticky status flags that the hash sequencer raises with single-cycle event pulses. Software reads these flags and clears them by writing ones. A per-flag enable register and a global enable decide which flags reach the combined interrupt line. A second, dedicated interrupt line reports that a partial hash is ready. This line depends only on the global enable.

The block also runs the context-switch handshake. Software asks for a switch by setting a request bit in the control word. The block then raises a hold output so that the sequencer issues no new input requests, and it waits until the sequencer reports that the block in progress has finished. At that point it raises one of two flags. Partial-hash-ready is raised when the interrupted work was an ordinary block. Output-ready is raised when that work was a final or outer hash. The request bit then clears itself.

Register map (word addresses): 0 holds the status flags, 1 holds the enables, and 2 is the control word. In the control word, bit 0 is the global enable and bit 1 is the context-switch request. Address 3 reads as zero.

Top module: `hirq_top`

## Requirements
- R1: After reset, the status, enable and control words all read 0, and both interrupt outputs are low.
- R2: Status bits are sticky and each one is set by its own event pulse: bit 0 output-ready by `ev_result`, bit 1 input-ready by `ev_in_req`, bit 3 context-ready by `ev_ctx_in`. Bit 2 partial-hash-ready is set only by the context-switch flow.
- R3: Writing the status word clears every bit written as 1 and leaves bits written as 0 unchanged. An event that arrives in the same cycle as a clear of the same bit wins, and the bit stays set.
- R4: The enable word uses the same bit layout as the status word and reads back as written. `irq_main` goes high exactly one cycle after some status bit and its enable bit are both 1 while the global enable is 1. It goes low one cycle after that condition ends.
- R5: `irq_part` follows status bit 2 ANDed with the global enable, one cycle later, whatever the enable word holds.
- R6: Writing 1 to control bit 1 starts a context switch. While the switch is pending, `in_hold` is high, and `ev_in_req` pulses are ignored: status bit 1 stays 0.
- R7: A pending switch completes only in a cycle where `seq_busy` is low. When `seq_final` is low in that cycle, status bit 2 is set and bit 0 is not.
- R8: When `seq_final` is high in the completing cycle, status bit 0 is set and bit 2 is not.
- R9: Control bit 1 reads 1 while the switch is pending and returns to 0 in the same edge that sets the completion flag. Writing 0 to it does not cancel a pending switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| ev_result | input | 1 | Pulse: result or context available |
| ev_in_req | input | 1 | Pulse: sequencer can accept the next 64-byte block |
| ev_ctx_in | input | 1 | Pulse: context loaded, ready to run |
| seq_busy | input | 1 | A block is being processed |
| seq_final | input | 1 | Current work is a final or outer hash |
| in_hold | output | 1 | Suppress new input requests |
| irq_main | output | 1 | Combined masked interrupt |
| irq_part | output | 1 | Partial-hash interrupt |

## Verification
A wrong flag bit shows up on the status readback one edge after the event that set it, and it shows on `irq_main` or `irq_part` one edge after that. A stuck or early context-switch state shows at once on `in_hold` and on control bit 1. A drain that completes while `seq_busy` is still high shows as status bit 2 or bit 0 appearing during the held-busy window. A swapped completion choice shows as the wrong one of bits 0 and 2 on the first readback after busy drops.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int NFLAG    = 4;
  localparam int B_OUT    = 0;
  localparam int B_INRDY  = 1;
  localparam int B_PART   = 2;
  localparam int B_CTXRDY = 3;

  localparam int A_STATUS = 0;
  localparam int A_ENABLE = 1;
  localparam int A_CTRL   = 2;

  localparam int C_GIE    = 0;
  localparam int C_CSREQ  = 1;

  typedef enum logic [0:0] {CS_IDLE = 1'b0, CS_DRAIN = 1'b1} cs_state_t;
endpackage

// File: rtl/hirq_status.sv
module hirq_status #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          clr_we,
  input  logic          en_we,
  input  logic [NF-1:0] wbits,
  output logic [NF-1:0] status_q,
  output logic [NF-1:0] enable_q
);
  logic [NF-1:0] clr_mask;
  logic [NF-1:0] status_d;
  logic [NF-1:0] enable_d;

  always_comb begin
    clr_mask = clr_we ? wbits : '0;
    status_d = (status_q & ~clr_mask) | set_vec;
    enable_d = en_we ? wbits : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (en_we) enable_q <= enable_d;
    end
  end

  // R2: a flag never falls unless it was written with 1
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr_mask)) == '0));
  // R3: a cleared bit without a same-cycle event reads 0 next
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & $past(wbits & ~set_vec)) == '0));
  // R3: an event always lands
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/hirq_ctxsw.sv
module hirq_ctxsw
  import hirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic seq_busy,
  input  logic seq_final,
  output logic pending,
  output logic set_part,
  output logic set_out
);
  cs_state_t state_q, state_d;
  logic      done;

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    case (state_q)
      CS_IDLE:  if (req_wr) state_d = CS_DRAIN;
      CS_DRAIN: if (!seq_busy) begin
        done    = 1'b1;
        state_d = CS_IDLE;
      end
      default:  state_d = CS_IDLE;
    endcase
    set_part = done & ~seq_final;
    set_out  = done &  seq_final;
    pending  = (state_q == CS_DRAIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_IDLE;
    else        state_q <= state_d;
  end

  // R7: no completion while the sequencer is busy
  a_r7_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && seq_busy) |=> pending);
  // R8: completion picks exactly one flag
  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_part && set_out));
endmodule

// File: rtl/hirq_gate.sv
module hirq_gate #(
  parameter int NF       = 4,
  parameter int PART_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] status,
  input  logic [NF-1:0] enable,
  input  logic          gie,
  output logic          irq_main,
  output logic          irq_part
);
  logic [NF-1:0] masked;
  logic          main_d, part_d;

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_mask
      assign masked[i] = status[i] & enable[i];
    end
  endgenerate

  always_comb begin
    main_d = gie & (|masked);
    part_d = gie & status[PART_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_main <= 1'b0;
      irq_part <= 1'b0;
    end else begin
      irq_main <= main_d;
      irq_part <= part_d;
    end
  end
endmodule

// File: rtl/hirq_top.sv
module hirq_top
  import hirq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_result,
  input  logic          ev_in_req,
  input  logic          ev_ctx_in,
  input  logic          seq_busy,
  input  logic          seq_final,
  output logic          in_hold,
  output logic          irq_main,
  output logic          irq_part
);
  logic [NFLAG-1:0] status_q, enable_q, set_vec;
  logic             gie_q;
  logic             we_stat, we_en, we_ctrl, req_wr;
  logic             pending, set_part, set_out;

  always_comb begin
    we_stat = reg_we && (reg_addr == AW'(A_STATUS));
    we_en   = reg_we && (reg_addr == AW'(A_ENABLE));
    we_ctrl = reg_we && (reg_addr == AW'(A_CTRL));
    req_wr  = we_ctrl && reg_wdata[C_CSREQ];
    set_vec = '0;
    set_vec[B_OUT]    = ev_result | set_out;
    set_vec[B_INRDY]  = ev_in_req & ~pending;
    set_vec[B_PART]   = set_part;
    set_vec[B_CTXRDY] = ev_ctx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_q <= 1'b0;
    else if (we_ctrl) gie_q <= reg_wdata[C_GIE];
  end

  hirq_status #(.NF(NFLAG)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_we(we_stat),
    .en_we(we_en), .wbits(reg_wdata[NFLAG-1:0]),
    .status_q(status_q), .enable_q(enable_q)
  );

  hirq_ctxsw u_ctxsw (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .seq_busy(seq_busy),
    .seq_final(seq_final), .pending(pending), .set_part(set_part),
    .set_out(set_out)
  );

  hirq_gate #(.NF(NFLAG), .PART_BIT(B_PART)) u_gate (
    .clk(clk), .rst_n(rst_n), .status(status_q), .enable(enable_q),
    .gie(gie_q), .irq_main(irq_main), .irq_part(irq_part)
  );

  assign in_hold = pending;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(A_STATUS): reg_rdata[NFLAG-1:0] = status_q;
      AW'(A_ENABLE): reg_rdata[NFLAG-1:0] = enable_q;
      AW'(A_CTRL): begin
        reg_rdata[C_GIE]   = gie_q;
        reg_rdata[C_CSREQ] = pending;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R4: combined line only with global enable in the previous cycle
  a_r4_main_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_main |-> $past(gie_q));
  // R5: partial line needs global enable and the partial flag
  a_r5_part_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_part |-> ($past(gie_q) && $past(status_q[B_PART])));
  // R6: no input-ready while a switch is pending
  a_r6_no_inrdy: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !status_q[B_INRDY] && !(reg_we && reg_addr == AW'(A_STATUS)))
      |=> !status_q[B_INRDY]);
  // R9: the end of a switch always leaves a completion flag
  a_r9_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !seq_busy) |=> (!pending && (status_q[B_OUT] || status_q[B_PART])));
endmodule

// File: tb/tb_hirq_top.sv
module tb_hirq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ev_result, ev_in_req, ev_ctx_in, seq_busy, seq_final;
  logic        in_hold, irq_main, irq_part;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  hirq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_result(ev_result),
    .ev_in_req(ev_in_req), .ev_ctx_in(ev_ctx_in), .seq_busy(seq_busy),
    .seq_final(seq_final), .in_hold(in_hold), .irq_main(irq_main),
    .irq_part(irq_part)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1 status", v, 0);
    rd(2'd1, v); chk("R1 enable", v, 0);
    rd(2'd2, v); chk("R1 control", v, 0);
    chk("R1 irqs", {irq_main, irq_part}, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    @(negedge clk); ev_result = 1'b1; tick(); ev_result = 1'b0;
    rd(2'd0, v); chk("R2 output-ready bit0", v, 32'h1);
    ev_ctx_in = 1'b1; tick(); ev_ctx_in = 1'b0;
    ev_in_req = 1'b1; tick(); ev_in_req = 1'b0;
    repeat (3) tick();
    rd(2'd0, v); chk("R2 sticky bits 0,1,3", v, 32'hB);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(2'd0, 32'h2); rd(2'd0, v); chk("R3 clear bit1", v, 32'h9);
    wr(2'd0, 32'h0); rd(2'd0, v); chk("R3 zero write no effect", v, 32'h9);
    wr(2'd0, 32'h9); rd(2'd0, v); chk("R3 clear all", v, 32'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1; ev_result = 1'b1;
    tick();
    reg_we = 1'b0; ev_result = 1'b0;
    rd(2'd0, v); chk("R3 set wins over clear", v, 32'h1);
  endtask

  task automatic t_main();
    logic [31:0] v;
    // status = 0x1 here
    wr(2'd1, 32'h1); rd(2'd1, v); chk("R4 enable readback", v, 32'h1);
    tick(); chk("R4 no irq without gie", irq_main, 0);
    wr(2'd2, 32'h1);
    chk("R4 irq registered, not yet", irq_main, 0);
    tick(); chk("R4 irq one cycle later", irq_main, 1);
    chk("R5 part low without flag", irq_part, 0);
    wr(2'd0, 32'h1);
    chk("R4 irq still high on clear edge", irq_main, 1);
    tick(); chk("R4 irq falls", irq_main, 0);
    @(negedge clk); ev_result = 1'b1; tick(); ev_result = 1'b0;
    wr(2'd1, 32'h8); tick(); chk("R4 mismatched enable masks", irq_main, 0);
    wr(2'd0, 32'hF);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_part();
    logic [31:0] v;
    @(negedge clk); seq_busy = 1'b1; seq_final = 1'b0;
    wr(2'd2, 32'h3);
    chk("R6 hold while pending", in_hold, 1);
    rd(2'd2, v); chk("R9 request reads 1", v, 32'h3);
    ev_in_req = 1'b1; tick(); ev_in_req = 1'b0;
    rd(2'd0, v); chk("R6 input-ready ignored", v, 32'h0);
    wr(2'd2, 32'h1);
    rd(2'd2, v); chk("R9 zero write keeps request", v, 32'h3);
    repeat (3) tick();
    rd(2'd0, v); chk("R7 no flag while busy", v, 32'h0);
    seq_busy = 1'b0; tick();
    rd(2'd0, v); chk("R7 partial flag only", v, 32'h4);
    rd(2'd2, v); chk("R9 request self-clears", v, 32'h1);
    chk("R6 hold released", in_hold, 0);
    tick();
    chk("R5 partial irq despite zero enables", irq_part, 1);
    chk("R4 main masked", irq_main, 0);
    wr(2'd2, 32'h0); tick();
    chk("R5 partial irq needs gie", irq_part, 0);
    ev_in_req = 1'b1; tick(); ev_in_req = 1'b0;
    rd(2'd0, v); chk("R6 input-ready after switch", v, 32'h6);
    wr(2'd0, 32'hF);
  endtask

  task automatic t_final();
    logic [31:0] v;
    @(negedge clk); seq_busy = 1'b0; seq_final = 1'b1;
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk("R9 pending after write", v, 32'h2);
    rd(2'd0, v); chk("R8 nothing before completion edge", v, 32'h0);
    tick();
    rd(2'd0, v); chk("R8 output-ready not partial", v, 32'h1);
    rd(2'd2, v); chk("R9 cleared after final", v, 32'h0);
    seq_final = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    ev_result = 1'b0; ev_in_req = 1'b0; ev_ctx_in = 1'b0;
    seq_busy = 1'b0; seq_final = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sticky();
    t_w1c();
    t_main();
    t_part();
    t_final();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule